// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block takes a DDR3 memory device from power-up to the point where a downstream memory controller may use it. After a synchronous reset it holds the device reset pin low. It then releases that pin while clock enable is still low, and waits a programmable settling interval before raising clock enable. It then writes the four mode registers in the fixed order MR2, MR3, MR1, MR0 and issues a long ZQ calibration. When the calibration interval has passed, it raises a ready flag.

Every interval is a parameter counted in controller clock cycles, so one body of logic serves any clock rate. The mode-register values are fixed: CAS latency 6, CAS write latency 5, burst length 8, write recovery 6, 34-ohm drive and 60-ohm termination. Only NOP is driven on the command pins outside the single-cycle command slots. A synchronous reset at any point restarts the whole sequence.

Top module: `ddr3_pwrup_seq`

## Requirements
- R1: While `rst` is high, and in the first sampled cycle after it falls, `mem_rst_n`=0, `mem_cke`=0, `init_done`=0, and the bus carries NOP: `mem_cs_n`=0, `mem_ras_n`=`mem_cas_n`=`mem_we_n`=1, with bank and address zero.
- R2: `mem_rst_n` stays low for exactly `T_RST` cycles after reset is released, with the bus at NOP.
- R3: `mem_rst_n` rises while `mem_cke` is low, and `mem_cke` stays low for exactly `T_CKE` cycles after that rise.
- R4: Once `mem_cke` rises, exactly `T_XPR` NOP cycles pass before the first command.
- R5: Exactly five commands are issued, in the order MR2, MR3, MR1, MR0, ZQCL. A mode-register write has `mem_cs_n`, `mem_ras_n`, `mem_cas_n` and `mem_we_n` all 0, with `mem_ba` equal to the register number (2, 3, 1, 0). ZQCL has `mem_cs_n`=0, `mem_ras_n`=1, `mem_cas_n`=1, `mem_we_n`=0, `mem_ba`=0 and address 0x400 (A10 set).
- R6: Each command lasts one cycle. Each mode-register write is followed by exactly `T_MOD` NOP cycles before the next command.
- R7: MR2 is written with address 0x000 (CAS write latency 5, all banks in partial-array self-refresh, auto self-refresh off, normal temperature, dynamic ODT off). MR3 is written with address 0x000 (multipurpose register off, predefined pattern).
- R8: MR1 is written with address 0x006: DLL enabled (A0=0), 34-ohm drive (A1=1, A5=0), 60-ohm termination (A2=1, A6=A9=0), additive latency 0, write leveling off, TDQS off and output buffer enabled (A12=0).
- R9: MR0 is written with address 0x520: burst length 8 (A1:0=00), sequential order (A3=0), CAS latency 6 (A6:4=010, A2=0), DLL reset (A8=1), write recovery 6 (A11:9=010) and DLL-off precharge power-down (A12=0).
- R10: `init_done` rises exactly `T_ZQ` NOP cycles after the ZQCL cycle. It then stays high with `mem_cke` high and the bus at NOP until the next reset.
- R11: A reset asserted partway through the sequence returns all outputs to the R1 state. After release, the full sequence runs again from the start with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset; restarts the sequence |
| mem_rst_n | output | 1 | Device reset, active low |
| mem_cke | output | 1 | Device clock enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | 3 | Bank address (mode-register select) |
| mem_addr | output | ADDR_W | Address bus (mode-register value) |
| init_done | output | 1 | Initialization complete, held until reset |

## Verification
The bench builds the block with short intervals: `T_RST`=20, `T_CKE`=50, `T_XPR`=5, `T_MOD`=4 and `T_ZQ`=12. With these values the whole sequence, up to and past `init_done`, lasts about 110 cycles. That makes it practical to compare every output pin against an arithmetically computed schedule on every cycle, so each phase length, each command slot and each gap is checked exactly, not only at its edges. The sweep is repeated after a reset injected during the gap that follows the MR1 write, to show that the restart reproduces the identical trace.

// File: rtl/ddr3_init_pkg.sv
package ddr3_init_pkg;

    localparam int BA_W  = 3;
    localparam int MRV_W = 13;   // A12..A0 carry every mode-register field
    localparam int STEPS = 5;    // MR2, MR3, MR1, MR0, ZQCL

    typedef enum logic [2:0] {
        PH_RST_HOLD,
        PH_CKE_WAIT,
        PH_XPR,
        PH_CMD,
        PH_GAP,
        PH_DONE
    } phase_t;

    typedef enum logic [1:0] {
        OP_NOP,
        OP_MRS,
        OP_ZQCL
    } op_t;

    typedef struct packed {
        op_t              op;
        logic [BA_W-1:0]  ba;
        logic [MRV_W-1:0] val;
    } step_word_t;

    // MR2: CWL 5 -> A5:3 = 000, PASR full array, ASR/SRT/Rtt_WR all zero
    function automatic logic [MRV_W-1:0] mr2_val();
        logic [MRV_W-1:0] v;
        v      = '0;
        v[5:3] = 3'b000;
        return v;
    endfunction

    // MR3: MPR off, predefined pattern location
    function automatic logic [MRV_W-1:0] mr3_val();
        logic [MRV_W-1:0] v;
        v      = '0;
        v[2]   = 1'b0;
        v[1:0] = 2'b00;
        return v;
    endfunction

    // MR1: DLL on, RZQ/7 drive, RZQ/4 termination, AL 0, Qoff enabled
    function automatic logic [MRV_W-1:0] mr1_val();
        logic [MRV_W-1:0] v;
        v     = '0;
        v[0]  = 1'b0;
        v[1]  = 1'b1;
        v[5]  = 1'b0;
        v[2]  = 1'b1;
        v[6]  = 1'b0;
        v[9]  = 1'b0;
        v[12] = 1'b0;
        return v;
    endfunction

    // MR0: BL8, sequential, CL6, DLL reset, WR6, slow-exit power-down
    function automatic logic [MRV_W-1:0] mr0_val();
        logic [MRV_W-1:0] v;
        v       = '0;
        v[1:0]  = 2'b00;
        v[3]    = 1'b0;
        v[6:4]  = 3'b010;
        v[2]    = 1'b0;
        v[8]    = 1'b1;
        v[11:9] = 3'b010;
        v[12]   = 1'b0;
        return v;
    endfunction

    function automatic step_word_t seq_word(input logic [2:0] step);
        step_word_t w;
        case (step)
            3'd0:    w = '{op: OP_MRS,  ba: 3'd2, val: mr2_val()};
            3'd1:    w = '{op: OP_MRS,  ba: 3'd3, val: mr3_val()};
            3'd2:    w = '{op: OP_MRS,  ba: 3'd1, val: mr1_val()};
            3'd3:    w = '{op: OP_MRS,  ba: 3'd0, val: mr0_val()};
            3'd4:    w = '{op: OP_ZQCL, ba: 3'd0, val: 13'h0400};
            default: w = '{op: OP_NOP,  ba: 3'd0, val: '0};
        endcase
        return w;
    endfunction

endpackage

// File: rtl/ddr3_init_timer.sv
module ddr3_init_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/ddr3_cmd_encode.sv
module ddr3_cmd_encode
    import ddr3_init_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  op_t               op,
    input  logic [BA_W-1:0]   ba_in,
    input  logic [MRV_W-1:0]  val_in,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);
    always_comb begin
        cs_n  = 1'b0;
        ras_n = 1'b1;
        cas_n = 1'b1;
        we_n  = 1'b1;
        ba    = '0;
        addr  = '0;
        case (op)
            OP_MRS: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
                we_n  = 1'b0;
                ba    = ba_in;
                addr  = ADDR_W'(val_in);
            end
            OP_ZQCL: begin
                we_n  = 1'b0;
                ba    = ba_in;
                addr  = ADDR_W'(val_in);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ddr3_pwrup_seq.sv
module ddr3_pwrup_seq
    import ddr3_init_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int T_RST  = 80000,
    parameter int T_CKE  = 200000,
    parameter int T_XPR  = 64,
    parameter int T_MOD  = 12,
    parameter int T_ZQ   = 512
) (
    input  logic              clk,
    input  logic              rst,
    output logic              mem_rst_n,
    output logic              mem_cke,
    output logic              mem_cs_n,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic [BA_W-1:0]   mem_ba,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              init_done
);
    localparam int MAX_A = (T_RST > T_CKE) ? T_RST : T_CKE;
    localparam int MAX_B = (T_XPR > T_MOD) ? T_XPR : T_MOD;
    localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_T = (MAX_C > T_ZQ) ? MAX_C : T_ZQ;
    localparam int CNT_W = $clog2(MAX_T + 1);
    localparam logic [2:0] LAST_STEP = 3'(STEPS - 1);

    phase_t           phase;
    logic [2:0]       step;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_zero;
    step_word_t       word;
    op_t              cur_op;

    ddr3_init_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_zero)
    );

    // Timer reload: each phase loads the length of the one that follows
    always_comb begin
        t_load = 1'b0;
        t_val  = '0;
        if (rst) begin
            t_load = 1'b1;
            t_val  = CNT_W'(T_RST - 1);
        end else begin
            case (phase)
                PH_RST_HOLD: if (t_zero) begin
                    t_load = 1'b1;
                    t_val  = CNT_W'(T_CKE - 1);
                end
                PH_CKE_WAIT: if (t_zero) begin
                    t_load = 1'b1;
                    t_val  = CNT_W'(T_XPR - 1);
                end
                PH_CMD: begin
                    t_load = 1'b1;
                    t_val  = (step == LAST_STEP) ? CNT_W'(T_ZQ - 1)
                                                 : CNT_W'(T_MOD - 1);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_RST_HOLD;
            step  <= '0;
        end else begin
            case (phase)
                PH_RST_HOLD: if (t_zero) phase <= PH_CKE_WAIT;
                PH_CKE_WAIT: if (t_zero) phase <= PH_XPR;
                PH_XPR:      if (t_zero) phase <= PH_CMD;
                PH_CMD:      phase <= PH_GAP;
                PH_GAP: if (t_zero) begin
                    if (step == LAST_STEP) begin
                        phase <= PH_DONE;
                    end else begin
                        step  <= step + 3'd1;
                        phase <= PH_CMD;
                    end
                end
                PH_DONE:     phase <= PH_DONE;
                default:     phase <= PH_RST_HOLD;
            endcase
        end
    end

    assign word   = seq_word(step);
    assign cur_op = (phase == PH_CMD) ? word.op : OP_NOP;

    ddr3_cmd_encode #(.ADDR_W(ADDR_W)) u_enc (
        .op     (cur_op),
        .ba_in  (word.ba),
        .val_in (word.val),
        .cs_n   (mem_cs_n),
        .ras_n  (mem_ras_n),
        .cas_n  (mem_cas_n),
        .we_n   (mem_we_n),
        .ba     (mem_ba),
        .addr   (mem_addr)
    );

    assign mem_rst_n = (phase != PH_RST_HOLD);
    assign mem_cke   = (phase == PH_XPR) || (phase == PH_CMD) ||
                       (phase == PH_GAP) || (phase == PH_DONE);
    assign init_done = (phase == PH_DONE);
endmodule

// File: rtl/ddr3_pwrup_seq_chk.sv
module ddr3_pwrup_seq_chk #(
    parameter int T_RST = 1,
    parameter int T_CKE = 1,
    parameter int T_MOD = 1
) (
    input logic clk,
    input logic rst,
    input logic mem_rst_n,
    input logic mem_cke,
    input logic mem_cs_n,
    input logic mem_ras_n,
    input logic mem_cas_n,
    input logic mem_we_n,
    input logic init_done
);
    logic        is_cmd;
    logic [31:0] low_cnt;
    logic [31:0] idle_cnt;
    logic [31:0] gap_cnt;
    logic        seen_cmd;

    assign is_cmd = !mem_cs_n && !(mem_ras_n && mem_cas_n && mem_we_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt  <= '0;
            idle_cnt <= '0;
            gap_cnt  <= '0;
            seen_cmd <= 1'b0;
        end else begin
            if (!mem_rst_n && low_cnt != '1)
                low_cnt <= low_cnt + 1;
            if (!mem_rst_n)
                idle_cnt <= '0;
            else if (!mem_cke && idle_cnt != '1)
                idle_cnt <= idle_cnt + 1;
            if (is_cmd) begin
                gap_cnt  <= '0;
                seen_cmd <= 1'b1;
            end else if (gap_cnt != '1) begin
                gap_cnt <= gap_cnt + 1;
            end
        end
    end

    AST_RESET_HOLD_MIN: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_rst_n) |-> (low_cnt >= 32'(T_RST))); // R2
    AST_CKE_LOW_AT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_rst_n) |-> !mem_cke); // R3
    AST_CKE_WAIT_MIN: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_cke) |-> (idle_cnt >= 32'(T_CKE))); // R3
    AST_CMD_NEEDS_CKE: assert property (@(posedge clk) disable iff (rst)
        is_cmd |-> (mem_cke && mem_rst_n)); // R5
    AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        is_cmd |=> !is_cmd); // R6
    AST_CMD_SPACING: assert property (@(posedge clk) disable iff (rst)
        (is_cmd && seen_cmd) |-> (gap_cnt >= 32'(T_MOD))); // R6
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        init_done |=> (init_done && mem_cke && !is_cmd)); // R10
endmodule

bind ddr3_pwrup_seq ddr3_pwrup_seq_chk #(
    .T_RST (T_RST),
    .T_CKE (T_CKE),
    .T_MOD (T_MOD)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_rst_n (mem_rst_n),
    .mem_cke   (mem_cke),
    .mem_cs_n  (mem_cs_n),
    .mem_ras_n (mem_ras_n),
    .mem_cas_n (mem_cas_n),
    .mem_we_n  (mem_we_n),
    .init_done (init_done)
);

// File: tb/test_ddr3_pwrup_seq.sv
`timescale 1ns / 1ps
module test_ddr3_pwrup_seq;
    localparam int AW = 14;
    localparam int TR = 20;
    localparam int TC = 50;
    localparam int TX = 5;
    localparam int TM = 4;
    localparam int TZ = 12;
    localparam int BASE = TR + TC + TX;
    localparam int DONE_AT = BASE + 4 * (1 + TM) + 1 + TZ;
    localparam int VW = 10 + AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mem_rst_n, mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, init_done;
    logic [2:0]    mem_ba;
    logic [AW-1:0] mem_addr;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    always #2.5 clk = ~clk;

    ddr3_pwrup_seq #(
        .ADDR_W(AW), .T_RST(TR), .T_CKE(TC), .T_XPR(TX), .T_MOD(TM), .T_ZQ(TZ)
    ) i_ddr3_pwrup_seq (
        .clk(clk), .rst(rst), .mem_rst_n(mem_rst_n), .mem_cke(mem_cke),
        .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
        .mem_we_n(mem_we_n), .mem_ba(mem_ba), .mem_addr(mem_addr),
        .init_done(init_done)
    );

    // {rst_n, cke, cs_n, ras_n, cas_n, we_n, ba, addr, done}
    function automatic logic [VW-1:0] mk(input logic rn, input logic ck,
            input logic [3:0] c, input logic [2:0] b, input logic [AW-1:0] a,
            input logic d);
        return {rn, ck, c, b, a, d};
    endfunction

    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_MRS = 4'b0000;
    localparam logic [3:0] C_ZQ  = 4'b0110;

    task automatic exp_at(input int i, output logic [VW-1:0] v, output string tag);
        int j, k, r, z;
        if (i < TR) begin
            v = mk(0, 0, C_NOP, 0, 0, 0); tag = (i == 0) ? "R1" : "R2";
        end else if (i < TR + TC) begin
            v = mk(1, 0, C_NOP, 0, 0, 0); tag = "R3";
        end else if (i < BASE) begin
            v = mk(1, 1, C_NOP, 0, 0, 0); tag = "R4";
        end else begin
            j = i - BASE;
            k = j / (1 + TM);
            r = j % (1 + TM);
            if (k < 4 && r == 0) begin
                case (k)
                    0: begin v = mk(1, 1, C_MRS, 3'd2, 14'h000, 0); tag = "R7"; end
                    1: begin v = mk(1, 1, C_MRS, 3'd3, 14'h000, 0); tag = "R7"; end
                    2: begin v = mk(1, 1, C_MRS, 3'd1, 14'h006, 0); tag = "R8"; end
                    default: begin v = mk(1, 1, C_MRS, 3'd0, 14'h520, 0); tag = "R9"; end
                endcase
            end else if (k < 4) begin
                v = mk(1, 1, C_NOP, 0, 0, 0); tag = "R6";
            end else if (j == 4 * (1 + TM)) begin
                v = mk(1, 1, C_ZQ, 3'd0, 14'h400, 0); tag = "R5";
            end else begin
                z = j - 4 * (1 + TM) - 1;
                v = mk(1, 1, C_NOP, 0, 0, (z >= TZ) ? 1'b1 : 1'b0); tag = "R10";
            end
        end
    endtask

    function automatic logic [VW-1:0] sample();
        return {mem_rst_n, mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n,
                mem_ba, mem_addr, init_done};
    endfunction

    task automatic check_vec(input string tag, input int cyc, input logic [VW-1:0] exp);
        logic [VW-1:0] got;
        got = sample();
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d: got %h expected %h", tag, cyc, got, exp);
        end
    endtask

    task automatic run_trace(input int n, input string pre);
        logic [VW-1:0] e;
        string t;
        for (int i = 0; i < n; i++) begin
            exp_at(i, e, t);
            check_vec({pre, t}, i, e);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_vec("R1", -1, mk(0, 0, C_NOP, 0, 0, 0));
        rst = 1'b0;
        run_trace(DONE_AT + 15, "");
        // reset while done: back to the idle state
        rst = 1'b1;
        @(negedge clk);
        check_vec("R1", -1, mk(0, 0, C_NOP, 0, 0, 0));
        rst = 1'b0;
        // abort in the gap after the MR1 write
        run_trace(BASE + 2 * (1 + TM) + 2, "R11 ");
        rst = 1'b1;
        @(negedge clk);
        check_vec("R11", -1, mk(0, 0, C_NOP, 0, 0, 0));
        rst = 1'b0;
        run_trace(DONE_AT + 15, "R11 ");
        ended = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!ended) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule